// File: doc/BRIEF.md
# Vector Length Override Update Unit

This block applies a 12-bit length-override field, taken from a wide prefixed instruction, to the architectural vector-length state: the maximum vector length (MVL) and the current vector length (VL). The field picks one of five actions. It can leave the state alone. It can set VL in a loop style, either from an immediate or from a scalar register. It can set MVL and VL together to one immediate. It can set only MVL and pull VL down to fit the new limit. Each action except the first can also return the resulting VL to a scalar register.

The decoder places the field on `ovr_field` and raises `ovr_valid` for one cycle. When a register supplies the length, the unit drives the source index on `rf_rd_idx` and takes the value from `rf_rd_data` in the same cycle. One cycle later the new state appears on `vl`, `mvl` and `len_state`. A write-back request, or an illegal-instruction pulse, appears in that same cycle.

Top module: `vlen_override_unit`

## Requirements
- R1: An override field of all zeros changes neither VL nor MVL and raises neither write-back nor illegal.
- R2: With field bit 11 = 0 and bit 0 = 0, VL becomes bits 5:1 plus one (0 gives 1, 31 gives 32), and MVL is unchanged.
- R3: With bit 11 = 0 and bit 0 = 1, `rf_rd_idx` carries bits 5:1 while `ovr_valid` is high. VL becomes `rf_rd_data`, or the current MVL when the value exceeds MVL. MVL is unchanged.
- R4: With bit 11 = 1 and bit 0 = 0, MVL and VL both become bits 5:1 plus one.
- R5: With bit 11 = 1 and bit 0 = 1, MVL becomes bits 5:1 plus one. VL keeps its value unless that value exceeds the new MVL, in which case VL becomes the new MVL.
- R6: For any nonzero, legal field whose bits 10:6 are nonzero, `wb_valid` pulses for one cycle. During that pulse `wb_idx` equals bits 10:6 and `wb_data` holds the new VL, zero-extended. When bits 10:6 are zero, no write-back occurs.
- R7: In register mode with source index 0, `illegal` pulses for one cycle. VL and MVL are unchanged and no write-back occurs.
- R8: Updates and pulses appear in the cycle after `ovr_valid`. Without `ovr_valid` the state holds and the pulses stay low.
- R9: Reset sets VL and MVL to 1 and clears `wb_valid` and `illegal`.
- R10: `len_state` packs MVL in bits 5:0 and VL in bits 11:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovr_valid | input | 1 | Override field is present this cycle |
| ovr_field | input | 12 | Length-override field |
| rf_rd_idx | output | 5 | Scalar source register index for register mode |
| rf_rd_data | input | XLEN | Value read from the scalar source register |
| vl | output | LEN_W | Current vector length |
| mvl | output | LEN_W | Current maximum vector length |
| len_state | output | 2*LEN_W | Packed state: MVL low, VL high |
| wb_valid | output | 1 | Scalar write-back request |
| wb_idx | output | 5 | Write-back destination register index |
| wb_data | output | XLEN | Write-back value (new VL) |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The bench builds the unit with its defaults: 6-bit length fields, a 64-bit register width and register-mode clamping enabled. The wide register port lets the bench drive values far above any MVL, which exercises the clamp. The 6-bit fields reach the top immediate of 32 without overflow. Random sequences of all five actions let MVL shrink below an earlier VL, so both the truncate path and the keep path are reached.

// File: rtl/vlo_pkg.sv
package vlo_pkg;
   typedef enum logic [2:0] {
      VLO_NONE     = 3'd0,
      VLO_LOOP_IMM = 3'd1,
      VLO_LOOP_REG = 3'd2,
      VLO_ONEOFF   = 3'd3,
      VLO_MVL_ONLY = 3'd4
   } vlo_mode_e;

   localparam int unsigned FIELD_W = 12;
   localparam int unsigned IMM_W   = 5;
   localparam int unsigned IDX_W   = 5;
endpackage

// File: rtl/vlo_decode.sv
module vlo_decode
   import vlo_pkg::*;
(
   input  logic [FIELD_W-1:0] field,
   output vlo_mode_e          mode,
   output logic [IMM_W-1:0]   imm,
   output logic [IDX_W-1:0]   dst_idx,
   output logic               bad_src
);
   always_comb begin
      imm     = field[5:1];
      dst_idx = field[10:6];
      if (field == '0)
         mode = VLO_NONE;
      else if (!field[11])
         mode = field[0] ? VLO_LOOP_REG : VLO_LOOP_IMM;
      else
         mode = field[0] ? VLO_MVL_ONLY : VLO_ONEOFF;
      bad_src = (mode == VLO_LOOP_REG) && (field[5:1] == '0);
   end
endmodule

// File: rtl/vlo_next_len.sv
module vlo_next_len
   import vlo_pkg::*;
#(
   parameter int unsigned LEN_W     = 6,
   parameter int unsigned XLEN      = 64,
   parameter bit          CLAMP_REG = 1'b1
) (
   input  vlo_mode_e        mode,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0]  reg_val,
   input  logic [LEN_W-1:0] cur_vl,
   input  logic [LEN_W-1:0] cur_mvl,
   output logic [LEN_W-1:0] nxt_vl,
   output logic [LEN_W-1:0] nxt_mvl
);
   logic [LEN_W-1:0] imm_p1;
   logic [LEN_W-1:0] reg_len;

   assign imm_p1 = LEN_W'(imm) + LEN_W'(1);

   generate
      if (CLAMP_REG) begin : g_clamp
         assign reg_len = (reg_val > XLEN'(cur_mvl)) ? cur_mvl
                                                     : reg_val[LEN_W-1:0];
      end else begin : g_trunc
         assign reg_len = reg_val[LEN_W-1:0];
      end
   endgenerate

   always_comb begin
      nxt_vl  = cur_vl;
      nxt_mvl = cur_mvl;
      unique case (mode)
         VLO_LOOP_IMM: nxt_vl = imm_p1;
         VLO_LOOP_REG: nxt_vl = reg_len;
         VLO_ONEOFF: begin
            nxt_vl  = imm_p1;
            nxt_mvl = imm_p1;
         end
         VLO_MVL_ONLY: begin
            nxt_mvl = imm_p1;
            nxt_vl  = (cur_vl > imm_p1) ? imm_p1 : cur_vl;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vlen_override_unit.sv
module vlen_override_unit
   import vlo_pkg::*;
#(
   parameter int unsigned LEN_W     = 6,
   parameter int unsigned XLEN      = 64,
   parameter bit          CLAMP_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ovr_valid,
   input  logic [FIELD_W-1:0]   ovr_field,
   output logic [IDX_W-1:0]     rf_rd_idx,
   input  logic [XLEN-1:0]      rf_rd_data,
   output logic [LEN_W-1:0]     vl,
   output logic [LEN_W-1:0]     mvl,
   output logic [2*LEN_W-1:0]   len_state,
   output logic                 wb_valid,
   output logic [IDX_W-1:0]     wb_idx,
   output logic [XLEN-1:0]      wb_data,
   output logic                 illegal
);
   localparam logic [LEN_W-1:0] RST_LEN = LEN_W'(1);

   generate
      if (LEN_W < IMM_W + 1) begin : g_bad_len
         $error("LEN_W must hold the largest immediate plus one");
      end
      if (XLEN < LEN_W) begin : g_bad_xlen
         $error("XLEN must be at least LEN_W");
      end
   endgenerate

   vlo_mode_e        mode;
   logic [IMM_W-1:0] imm;
   logic [IDX_W-1:0] dst_idx;
   logic             bad_src;
   logic [LEN_W-1:0] vl_q, mvl_q, nxt_vl, nxt_mvl;
   logic             take;

   vlo_decode u_dec (
      .field   (ovr_field),
      .mode    (mode),
      .imm     (imm),
      .dst_idx (dst_idx),
      .bad_src (bad_src)
   );

   vlo_next_len #(.LEN_W(LEN_W), .XLEN(XLEN), .CLAMP_REG(CLAMP_REG)) u_nxt (
      .mode    (mode),
      .imm     (imm),
      .reg_val (rf_rd_data),
      .cur_vl  (vl_q),
      .cur_mvl (mvl_q),
      .nxt_vl  (nxt_vl),
      .nxt_mvl (nxt_mvl)
   );

   assign rf_rd_idx = imm;
   assign take      = ovr_valid && (mode != VLO_NONE) && !bad_src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vl_q     <= RST_LEN;
         mvl_q    <= RST_LEN;
         wb_valid <= 1'b0;
         wb_idx   <= '0;
         wb_data  <= '0;
         illegal  <= 1'b0;
      end else begin
         illegal  <= ovr_valid && bad_src;
         wb_valid <= take && (dst_idx != '0);
         if (take) begin
            vl_q    <= nxt_vl;
            mvl_q   <= nxt_mvl;
            wb_idx  <= dst_idx;
            wb_data <= XLEN'(nxt_vl);
         end
      end
   end

   assign vl        = vl_q;
   assign mvl       = mvl_q;
   assign len_state = {vl_q, mvl_q};
endmodule

// File: rtl/vlo_checker.sv
module vlo_checker
   import vlo_pkg::*;
#(
   parameter int unsigned LEN_W = 6,
   parameter int unsigned XLEN  = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ovr_valid,
   input logic [FIELD_W-1:0] ovr_field,
   input logic [LEN_W-1:0]   vl,
   input logic [LEN_W-1:0]   mvl,
   input logic               wb_valid,
   input logic [IDX_W-1:0]   wb_idx,
   input logic [XLEN-1:0]    wb_data,
   input logic               illegal
);
   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid && ovr_field == '0) |=> ($stable(vl) && $stable(mvl) && !wb_valid && !illegal)); // R1
   AST_ONEOFF_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid && ovr_field[11] && !ovr_field[0]) |=>
      (vl == mvl && mvl == LEN_W'($past(ovr_field[5:1])) + LEN_W'(1))); // R4
   AST_MVL_ONLY_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid && ovr_field[11] && ovr_field[0]) |=> (vl <= mvl)); // R5
   AST_X0_SOURCE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_valid && !ovr_field[11] && ovr_field[0] && ovr_field[5:1] == '0) |=>
      (illegal && !wb_valid && $stable(vl) && $stable(mvl))); // R7
   AST_WB_CARRIES_VL: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_data == XLEN'(vl) && wb_idx != '0)); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_valid |=> (!wb_valid && !illegal && $stable(vl) && $stable(mvl))); // R8
endmodule

bind vlen_override_unit vlo_checker #(.LEN_W(LEN_W), .XLEN(XLEN)) u_vlo_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ovr_valid (ovr_valid),
   .ovr_field (ovr_field),
   .vl        (vl),
   .mvl       (mvl),
   .wb_valid  (wb_valid),
   .wb_idx    (wb_idx),
   .wb_data   (wb_data),
   .illegal   (illegal)
);

// File: tb/vlen_override_unit_tb.sv
module vlen_override_unit_tb;
   localparam int unsigned LEN_W = 6;
   localparam int unsigned XLEN  = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ovr_valid = 1'b0;
   logic [11:0]       ovr_field = '0;
   logic [4:0]        rf_rd_idx;
   logic [XLEN-1:0]   rf_rd_data = '0;
   logic [LEN_W-1:0]  vl, mvl;
   logic [2*LEN_W-1:0] len_state;
   logic              wb_valid, illegal;
   logic [4:0]        wb_idx;
   logic [XLEN-1:0]   wb_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [LEN_W-1:0] m_vl, m_mvl;

   always #2 clk = ~clk;

   vlen_override_unit #(.LEN_W(LEN_W), .XLEN(XLEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .ovr_valid(ovr_valid), .ovr_field(ovr_field),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .vl(vl), .mvl(mvl),
      .len_state(len_state), .wb_valid(wb_valid), .wb_idx(wb_idx),
      .wb_data(wb_data), .illegal(illegal)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [LEN_W-1:0] p1(input logic [11:0] f);
      return LEN_W'(f[5:1]) + LEN_W'(1);
   endfunction

   task automatic apply(input logic [11:0] f, input logic [XLEN-1:0] rd);
      logic [LEN_W-1:0] e_vl, e_mvl;
      logic e_ill, e_wb;
      e_vl = m_vl; e_mvl = m_mvl; e_ill = 1'b0;
      if (f == '0) begin
         // R1 no change
      end else if (!f[11] && !f[0]) e_vl = p1(f);                     // R2
      else if (!f[11] && f[0]) begin
         if (f[5:1] == '0) e_ill = 1'b1;                              // R7
         else e_vl = (rd > XLEN'(m_mvl)) ? m_mvl : rd[LEN_W-1:0];     // R3
      end else if (!f[0]) begin e_vl = p1(f); e_mvl = p1(f); end      // R4
      else begin e_mvl = p1(f); if (m_vl > e_mvl) e_vl = e_mvl; end   // R5
      e_wb = (f != '0) && !e_ill && (f[10:6] != '0);                  // R6
      @(negedge clk);
      ovr_valid = 1'b1; ovr_field = f; rf_rd_data = rd;
      #1;
      if (!f[11] && f[0]) check("R3 rd_idx", 64'(rf_rd_idx), 64'(f[5:1]));
      check("R8 no early change", 64'(vl), 64'(m_vl));
      @(negedge clk);
      ovr_valid = 1'b0;
      check("R2/R3/R4/R5 vl", 64'(vl), 64'(e_vl));
      check("R4/R5 mvl", 64'(mvl), 64'(e_mvl));
      check("R10 len_state", 64'(len_state), 64'({e_vl, e_mvl}));
      check("R7 illegal", 64'(illegal), 64'(e_ill));
      check("R6 wb_valid", 64'(wb_valid), 64'(e_wb));
      if (e_wb) begin
         check("R6 wb_idx", 64'(wb_idx), 64'(f[10:6]));
         check("R6 wb_data", wb_data, 64'(e_vl));
      end
      m_vl = e_vl; m_mvl = e_mvl;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] seed;
      seed = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      check("R9 vl reset", 64'(vl), 64'd1);
      check("R9 mvl reset", 64'(mvl), 64'd1);
      check("R9 wb reset", 64'(wb_valid), 64'd0);
      check("R9 illegal reset", 64'(illegal), 64'd0);
      rst_n = 1'b1;
      m_vl = 1; m_mvl = 1;
      // directed corners
      apply(12'h000, 64'd9);                                   // R1
      apply({1'b1, 5'd3, 5'd31, 1'b0}, 64'd0);                 // R4 to 32, wb x3
      apply({1'b0, 5'd0, 5'd0, 1'b0}, 64'd0);                  // R2 imm 0 -> 1, no wb
      apply({1'b0, 5'd7, 5'd31, 1'b0}, 64'd0);                 // R2 imm 31 -> 32
      apply({1'b0, 5'd4, 5'd0, 1'b1}, 64'd5);                  // R7 x0 source
      apply({1'b0, 5'd4, 5'd9, 1'b1}, 64'hFFFF_0000_0000_0001); // R3 clamp
      apply({1'b0, 5'd4, 5'd9, 1'b1}, 64'd17);                 // R3 in range
      apply({1'b1, 5'd2, 5'd7, 1'b1}, 64'd0);                  // R5 truncate to 8
      apply({1'b1, 5'd2, 5'd20, 1'b1}, 64'd0);                 // R5 keep 8
      apply(12'h000, 64'd0);                                   // R1
      @(negedge clk);
      check("R8 idle wb", 64'(wb_valid), 64'd0);
      for (int i = 0; i < 400; i++) begin
         logic [11:0] f;
         logic [XLEN-1:0] rd;
         f  = 12'($urandom);
         if (($urandom % 8) == 0) f = '0;
         rd = (($urandom % 4) == 0) ? {$urandom, $urandom} : XLEN'($urandom % 70);
         apply(f, rd);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule